// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by walking a two-level page table in memory. The virtual address is cut into three fields: the top ten bits index the outer table, the next ten bits index an inner table, and the low twelve bits are the offset within a 4 KiB page. A base register gives the start of the outer table. The walker makes one read into the outer table. The valid entry it gets back gives the start of the inner table. A second read into the inner table gives the frame number, and the walker joins that frame number with the unchanged offset.

An entry is one 32-bit word. Bit 0 is the valid flag, and bits [31:12] hold either the next table's base or the frame number. An entry whose valid flag is clear stops the walk and reports a page fault. This applies at either level. The walker handles one translation at a time, accepted through a valid/ready handshake. It reaches memory through a read port: a one-cycle request pulse carries the address, and a response arrives some cycles later with the data. The result comes back as a one-cycle done pulse together with a fault flag. The virtual address of the last fault is held on an output for software to read.

Top module: `ptw_two_level`

## Requirements
- R1: After reset, req_ready is 1, and done, fault, mem_req, paddr and fault_vaddr are all 0.
- R2: A request is accepted only in a cycle where req_ready is 1. req_ready is 0 from the cycle after acceptance until the walk has finished, and a req_valid raised in that time has no effect on the result.
- R3: The first read of a walk goes to the address base + vaddr[31:22]*4, where base is the base register's value.
- R4: After a valid outer entry, the second read goes to {outer_entry[31:12], 12'h000} + vaddr[21:12]*4.
- R5: After a valid inner entry, done pulses with fault = 0 and paddr = {inner_entry[31:12], vaddr[11:0]}.
- R6: An outer entry with bit 0 = 0 ends the walk with done = 1 and fault = 1, and no second read is made.
- R7: An inner entry with bit 0 = 0 ends the walk with done = 1 and fault = 1.
- R8: fault_vaddr takes the faulting virtual address in the cycle fault is raised and keeps its value through walks that succeed.
- R9: A base register write (base_wr_en) takes effect only while req_ready is 1. A write made during a walk is dropped.
- R10: Each table read is a single-cycle mem_req pulse. mem_req is never high while req_ready is 1.
- R11: done lasts exactly one cycle, and req_ready is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Write strobe for the outer-table base register |
| base_wr_data | input | 32 | New outer-table base |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_req | output | 1 | One-cycle read request to table memory |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Qualifies done: the walk hit an invalid entry |
| paddr | output | 32 | Translated physical address, updated on success |
| fault_vaddr | output | 32 | Virtual address of the most recent fault |

## Verification
Several handshake rules are checked by the assertions on every cycle. The read request is one cycle wide and never appears while the walker is idle. done falls after one cycle and hands control back to the idle state. fault only ever appears together with done. The base register does not move while a walk is in flight, and fault_vaddr changes only together with fault. The content of the walk needs the bench's scenarios, because it depends on what the table memory holds. These cover the two read addresses built from the base and the index fields, the joined physical address, the choice of fault level, and the count of reads after an outer fault. The scenarios also show that a dropped base write or a request made while busy leaves the next result unchanged.

// File: rtl/ptw_pkg.sv
// Package: shared walk state encoding and entry field positions.
// Assumes entries are one word with the valid flag in the lowest bit.
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OUTER,
        ST_RD_INNER,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    localparam int ENTRY_VALID_BIT = 0;
    localparam int ENTRY_SIZE_LOG2 = 2;
endpackage

// File: rtl/ptw_base_reg.sv
// Outer-table base register. A write lands only when wr_allow is high.
// Assumes the owner raises wr_allow exclusively while no walk is running.
module ptw_base_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_allow,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] base_q
);
    // Hold the base; accept a write only when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (wr_en && wr_allow)
            base_q <= wr_data;
    end

    // R9: base is frozen across any cycle in which writes are not allowed
    a_r9_base_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(base_q));
endmodule

// File: rtl/ptw_index_addr.sv
// Entry address generator: table base plus index scaled by the entry size.
// Assumes the base is aligned so the sum does not wrap.
module ptw_index_addr #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 10,
    parameter int SIZE_LOG2 = 2
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - SIZE_LOG2;

    logic [ADDR_W-1:0] scaled;

    // Scale the index into a byte offset and add it to the base.
    always_comb begin
        scaled     = {{PAD_W{1'b0}}, index, {SIZE_LOG2{1'b0}}};
        entry_addr = table_base + scaled;
    end
endmodule

// File: rtl/ptw_two_level.sv
// Two-level page table walker. It takes one virtual address and reads the
// outer entry, then the inner entry, and returns the physical address or a fault.
// Assumes memory answers each single-cycle request with exactly one
// response pulse, no earlier than the cycle after the request.
module ptw_two_level #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_wr_en,
    input  logic [PA_W-1:0] base_wr_data,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            req_ready,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data,
    output logic            done,
    output logic            fault,
    output logic [PA_W-1:0] paddr,
    output logic [VA_W-1:0] fault_vaddr
);
    import ptw_pkg::*;

    localparam int FRAME_W   = PA_W - OFF_W;
    localparam int OUTER_LSB = OFF_W + IDX_W;

    walk_state_t       st_q, st_d;
    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   inner_base_q;
    logic [PA_W-1:0]   paddr_q;
    logic [VA_W-1:0]   fva_q;
    logic              issued_q;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   outer_addr, inner_addr;
    logic [IDX_W-1:0]  outer_idx, inner_idx;
    logic              rsp_take, entry_ok, in_read, accept;

    assign outer_idx = va_q[OUTER_LSB +: IDX_W];
    assign inner_idx = va_q[OFF_W +: IDX_W];
    assign in_read   = (st_q == ST_RD_OUTER) || (st_q == ST_RD_INNER);
    assign rsp_take  = mem_rsp_valid && issued_q && in_read;
    assign entry_ok  = mem_rsp_data[ENTRY_VALID_BIT];
    assign accept    = req_valid && req_ready;

    assign req_ready   = (st_q == ST_IDLE);
    assign mem_req     = in_read && !issued_q;
    assign mem_addr    = (st_q == ST_RD_INNER) ? inner_addr : outer_addr;
    assign done        = (st_q == ST_DONE) || (st_q == ST_FAULT);
    assign fault       = (st_q == ST_FAULT);
    assign paddr       = paddr_q;
    assign fault_vaddr = fva_q;

    ptw_base_reg #(.W(PA_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (base_wr_en),
        .wr_allow (req_ready),
        .wr_data  (base_wr_data),
        .base_q   (base_q)
    );

    ptw_index_addr #(.ADDR_W(PA_W), .IDX_W(IDX_W), .SIZE_LOG2(ENTRY_SIZE_LOG2)) u_outer_addr (
        .table_base (base_q),
        .index      (outer_idx),
        .entry_addr (outer_addr)
    );

    ptw_index_addr #(.ADDR_W(PA_W), .IDX_W(IDX_W), .SIZE_LOG2(ENTRY_SIZE_LOG2)) u_inner_addr (
        .table_base (inner_base_q),
        .index      (inner_idx),
        .entry_addr (inner_addr)
    );

    // Next-state selection for the walk sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (accept) st_d = ST_RD_OUTER;
            ST_RD_OUTER: if (rsp_take) st_d = entry_ok ? ST_RD_INNER : ST_FAULT;
            ST_RD_INNER: if (rsp_take) st_d = entry_ok ? ST_DONE : ST_FAULT;
            ST_DONE:     st_d = ST_IDLE;
            ST_FAULT:    st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // State, request tracking and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            va_q         <= '0;
            inner_base_q <= '0;
            paddr_q      <= '0;
            fva_q        <= '0;
            issued_q     <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept)
                va_q <= req_vaddr;
            if (mem_req)
                issued_q <= 1'b1;
            else if (rsp_take)
                issued_q <= 1'b0;
            if (rsp_take && !entry_ok)
                fva_q <= va_q;
            if (rsp_take && entry_ok && st_q == ST_RD_OUTER)
                inner_base_q <= {mem_rsp_data[PA_W-1:OFF_W], {OFF_W{1'b0}}};
            if (rsp_take && entry_ok && st_q == ST_RD_INNER)
                paddr_q <= {mem_rsp_data[PA_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
        end
    end

    // R10: no memory request while idle
    a_r10_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
    // R10: each request is a single-cycle pulse
    a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R11: done lasts one cycle and the walker is ready next
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    // R6/R7: a fault is always reported with done
    a_r6_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);
    // R8: the fault address moves only when a fault is reported
    a_r8_fva_only_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_vaddr) |-> fault);
    // R2: ready stays low once a request was taken
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_ptw_two_level.sv
module sim_ptw_two_level;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    // {expected reads[1:0], expected fault, vaddr[31:0], expected paddr[31:0]}
    localparam logic [66:0] VEC [NVEC] = '{
        {2'd2, 1'b0, 32'h0000_0123, 32'hABCD_E123},
        {2'd2, 1'b0, 32'h0000_5FFF, 32'h1234_5FFF},
        {2'd2, 1'b1, 32'h0000_7000, 32'h0000_0000},
        {2'd1, 1'b1, 32'h0040_0ABC, 32'h0000_0000},
        {2'd2, 1'b0, 32'hFFFF_F001, 32'hFFFF_F001},
        {2'd2, 1'b0, 32'hFFC0_0000, 32'hABCD_E000},
        {2'd2, 1'b0, 32'h0000_03FF, 32'hABCD_E3FF}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        base_wr_en = 0;
    logic [31:0] base_wr_data = 0;
    logic        req_valid = 0;
    logic [31:0] req_vaddr = 0;
    logic        req_ready, mem_req, done, fault;
    logic [31:0] mem_addr, paddr, fault_vaddr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [4096];
    logic [31:0] rd_log [64];
    int          rd_cnt = 0;
    logic        pend = 0;
    int          wait_c = 0;
    logic [31:0] a_q = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_two_level u0 (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .paddr(paddr), .fault_vaddr(fault_vaddr)
    );

    // Table memory model: answers each request two cycles later and logs the address.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req) begin
            pend   <= 1'b1;
            wait_c <= 2;
            a_q    <= mem_addr;
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end else if (pend) begin
            if (wait_c == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[a_q[13:2]];
                pend <= 1'b0;
            end
            wait_c <= wait_c - 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            if (done) return;
            @(negedge clk);
        end
        bad++;
        $display("FAIL R11 no done pulse actual=0 expected=1");
    endtask

    task automatic start(input logic [31:0] va);
        @(negedge clk);
        req_valid = 1; req_vaddr = va;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_wr_en = 1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[12'h400] = 32'h0000_3001;   // outer @0x1000 idx 0
        mem[12'h401] = 32'h0000_0000;   // outer idx 1 invalid
        mem[12'h7FF] = 32'h0000_3001;   // outer idx 0x3FF
        mem[12'h800] = 32'h0000_0000;   // alt outer @0x2000 idx 0 invalid
        mem[12'h801] = 32'h0000_3001;   // alt outer idx 1
        mem[12'hC00] = 32'hABCD_E001;   // inner @0x3000 idx 0
        mem[12'hC05] = 32'h1234_5001;
        mem[12'hC07] = 32'h1234_0000;   // invalid, frame bits set
        mem[12'hFFF] = 32'hFFFF_F001;

        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 req_ready", {31'b0, req_ready}, 32'h1);
        check("R1 done/fault/mem_req", {29'b0, done, fault, mem_req}, 32'h0);
        check("R1 paddr", paddr, 32'h0);
        check("R1 fault_vaddr", fault_vaddr, 32'h0);
        rst_n = 1;

        set_base(32'h0000_1000);

        // Vector table walk: R3, R4, R5, R6, R7
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] va, epa, a1, a2;
            logic        efault;
            int          enrd, c0;
            {enrd[1:0], efault, va, epa} = VEC[v];
            enrd = int'(VEC[v][66:65]);
            c0 = rd_cnt;
            start(va);
            wait_done();
            a1 = 32'h1000 + {20'b0, va[31:22], 2'b00};
            check("R3 outer read addr", rd_log[c0 % 64], a1);
            check("R6/R7 fault flag", {31'b0, fault}, {31'b0, efault});
            check("R6 read count", rd_cnt - c0, enrd);
            if (enrd == 2) begin
                a2 = {mem[a1[13:2]][31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
                check("R4 inner read addr", rd_log[(c0 + 1) % 64], a2);
            end
            if (efault) check("R8 fault_vaddr", fault_vaddr, va);
            else        check("R5 paddr", paddr, epa);
            @(negedge clk);
            check("R11 done one cycle", {30'b0, done, req_ready}, 32'h1);
        end

        // R8: after a success, fault_vaddr still holds the last fault (vector 6 ok, last fault was vector 3)
        check("R8 fault_vaddr held", fault_vaddr, 32'h0040_0ABC);

        // R2: request raised while busy has no effect
        begin
            int c0;
            c0 = rd_cnt;
            start(32'h0000_5ABC);
            req_valid = 1; req_vaddr = 32'hFFFF_F000;
            check("R2 not ready while busy", {31'b0, req_ready}, 32'h0);
            @(negedge clk); @(negedge clk);
            req_valid = 0;
            wait_done();
            check("R2 busy request ignored", paddr, 32'h1234_5ABC);
            @(negedge clk);
            check("R2 only one walk", rd_cnt - c0, 2);
        end

        // R9: base write during a walk is dropped
        start(32'h0000_0456);
        base_wr_en = 1; base_wr_data = 32'h0000_2000;
        @(negedge clk);
        base_wr_en = 0;
        wait_done();
        @(negedge clk);
        start(32'h0000_0789);
        wait_done();
        check("R9 busy write dropped", paddr, 32'hABCD_E789);

        // R9: base write while idle takes effect
        set_base(32'h0000_2000);
        begin
            int c0;
            c0 = rd_cnt;
            start(32'h0040_0321);
            wait_done();
            check("R9 idle write used", rd_log[c0 % 64], 32'h0000_2004);
            check("R9 idle write result", paddr, 32'hABCD_E321);
        end
        start(32'h0000_0FFF);
        wait_done();
        check("R6 fault on new base", {31'b0, fault}, 32'h1);
        check("R8 fault_vaddr new", fault_vaddr, 32'h0000_0FFF);
        check("R5 paddr kept on fault", paddr, 32'hABCD_E321);

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule